// File: doc/BRIEF.md
# SCSI Initiator Controller Command and Interrupt Register Block

This block is the byte-wide register front end of a simple SCSI bus-initiator controller. A host reaches sixteen byte registers through a strobed read/write port. The incoming address is shifted right by a parameter before the register index is taken, and reads and writes land in separate register sets, so a location can hold one value for writes and show another on readback. A byte written to the command register is decoded into an opcode plus a DMA qualifier, and the opcode updates the status, interrupt-cause and sequence-step registers. The block drives one level-sensitive interrupt line.

Selection commands start a handshake with the bus logic outside the block. The block waits for the DMA-enable input, emits a one-cycle `sel_go` pulse, and then waits for a `sel_done` pulse whose `sel_found` flag reports whether a target answered. Bus phases, target lookup and the data path are outside this block. A synchronous external reset input restores the power-up state.

Top module: `scsi_ctl_regs`

## Requirements
- R1: After reset every readable register is 0x00 except index 0x8 (config 1) = 0x07 and index 0xE (count high / chip id) = 0x04; `irq` is low, and the write-side copy of config 1 is zero.
- R2: The register index is `addr >> ADDR_SHIFT`; the low ADDR_SHIFT address bits have no effect.
- R3: A read of the interrupt register (0x5) returns its value from before the read. After that clock edge the interrupt register is 0x00, the sequence step (0x6) is 4, status (0x4) bits 7 and 4 are clear, and `irq` is low.
- R4: Command 0x03 (bus reset) sets the interrupt register to 0x80. It raises the interrupt only when bit 6 of the written config 1 value is 0.
- R5: Command 0x12 (message accept) sets the interrupt register to 0x20, clears the sequence step and FIFO flags (0x7), and raises the interrupt. Command 0x18 (pad) sets status bits 6:0 to 0x10 and the interrupt register to 0x08, clears the sequence step, and leaves `irq` unchanged.
- R6: Command 0x01 (flush) sets the interrupt register to 0x08 and clears the sequence step and FIFO flags without touching `irq`. Command 0x44 clears the interrupt register. Commands 0x00 and 0x1A, and every unlisted opcode, change nothing except the readable command register (0x3).
- R7: Command 0x02 (reset) and a pulse on `ext_rst` both restore the R1 state, including a readable command register of 0x00, and drop `irq`.
- R8: Writes to 0x8, 0xB, 0xC, 0xD, 0xE and 0xF read back. Writes to 0x2, 0x4 to 0x7, 0x9 and 0xA leave readback unchanged. Writes to 0x0 and 0x1 reach the readable count only when a command byte with bit 7 set is written, and each of them clears status bit 4.
- R9: Command 0x11 (initiator complete) without bit 7 ORs 0x87 into status, sets FIFO flags to 2 and the interrupt register to 0x08. With bit 7 (0x91) it sets status to 0x97, the interrupt register to 0x08 and the sequence step to 4.
- R10: Commands 0x41, 0x42 and 0x43 request a selection. `sel_go` pulses one cycle after the command when `dma_en` is high, otherwise one cycle after `dma_en` is first seen high. `sel_done` is ignored while no selection awaits it.
- R11: A `sel_done` that answers a selection updates the registers on the next edge. Not found: status 0x80, interrupt 0x20, sequence 0. Found after 0x43: status 0x92, interrupt 0x18, sequence 4. Found after 0x41 or 0x42: interrupt 0x18, sequence 4, status bit 7 set and the other status bits kept.
- R12: `irq` equals status bit 7, and a second interrupt-raising event while it is set leaves it set with no other effect. Command 0x90 (transfer information with DMA) clears status bit 4. Command 0x10 leaves status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_rst | input | 1 | Synchronous reset request from outside the block |
| dma_en | input | 1 | DMA engine ready; selections wait for it |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; its side effects apply at the clock edge |
| addr | input | ADDR_SHIFT+4 | Byte address before the shift |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register (combinational) |
| irq | output | 1 | Level interrupt request |
| sel_go | output | 1 | One-cycle pulse that starts a bus selection |
| sel_done | input | 1 | One-cycle pulse that ends a selection |
| sel_found | input | 1 | Target responded (valid with sel_done) |

## Verification
Every register effect of a write, a read side effect or a `sel_done` pulse is due after the one rising edge that samples the strobe, and `irq` follows on that same edge. `rdata` is combinational, so the value a read returns is due in the cycle of the strobe, before that edge. `sel_go` is due one edge after the command or after `dma_en` is seen high. The bench drives every strobe for exactly one cycle on the falling edge. It captures `rdata` shortly after driving the read, and it checks all other results on the next falling edge, one rising edge later.

// File: rtl/scsi_ctl_pkg.sv
package scsi_ctl_pkg;

  localparam int REG_N   = 16;
  localparam int IDX_W   = $clog2(REG_N);

  // register indices whose position the decode depends on
  localparam logic [IDX_W-1:0] IX_CNT_LO  = 4'h0;
  localparam logic [IDX_W-1:0] IX_CNT_MID = 4'h1;
  localparam logic [IDX_W-1:0] IX_CMD     = 4'h3;
  localparam logic [IDX_W-1:0] IX_STAT    = 4'h4;
  localparam logic [IDX_W-1:0] IX_INTR    = 4'h5;
  localparam logic [IDX_W-1:0] IX_SEQ     = 4'h6;
  localparam logic [IDX_W-1:0] IX_FLAGS   = 4'h7;
  localparam logic [IDX_W-1:0] IX_CFG1    = 4'h8;
  localparam logic [IDX_W-1:0] IX_CNT_HI  = 4'hE;

  // status bits
  localparam int ST_PEND = 7;
  localparam int ST_TCZ  = 4;

  // interrupt cause codes
  localparam logic [7:0] IC_DONE   = 8'h08;
  localparam logic [7:0] IC_SVC    = 8'h10;
  localparam logic [7:0] IC_DISC   = 8'h20;
  localparam logic [7:0] IC_BUSRST = 8'h80;

  localparam logic [7:0] CHIP_ID   = 8'h04;
  localparam logic [7:0] CFG1_INIT = 8'h07;
  localparam int         CFG1_QUIET_BIT = 6;

  typedef enum logic [3:0] {
    OP_NOP, OP_FLUSH, OP_RESET, OP_BUSRST, OP_XFER, OP_ICMPL, OP_MSGACC,
    OP_PAD, OP_SETATN, OP_SEL, OP_SELATN, OP_SELSTOP, OP_RESEL, OP_UNKNOWN
  } op_e;

  typedef enum logic [1:0] {S_IDLE, S_WAIT_DMA, S_WAIT_BUS} sel_st_e;

  typedef struct packed {
    logic valid;
    logic found;
    logic stop;
  } sel_res_t;

  typedef logic [REG_N-1:0][7:0] regimg_t;

  function automatic regimg_t reset_image();
    regimg_t img;
    img = '0;
    img[IX_CFG1]   = CFG1_INIT;
    img[IX_CNT_HI] = CHIP_ID;
    return img;
  endfunction

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_ctl_pkg::*;
(
  input  logic [7:0] cmd_i,
  output op_e        op_o,
  output logic       dma_o
);

  assign dma_o = cmd_i[7];

  always_comb begin
    unique case (cmd_i[6:0])
      7'h00:   op_o = OP_NOP;
      7'h01:   op_o = OP_FLUSH;
      7'h02:   op_o = OP_RESET;
      7'h03:   op_o = OP_BUSRST;
      7'h10:   op_o = OP_XFER;
      7'h11:   op_o = OP_ICMPL;
      7'h12:   op_o = OP_MSGACC;
      7'h18:   op_o = OP_PAD;
      7'h1A:   op_o = OP_SETATN;
      7'h41:   op_o = OP_SEL;
      7'h42:   op_o = OP_SELATN;
      7'h43:   op_o = OP_SELSTOP;
      7'h44:   op_o = OP_RESEL;
      default: op_o = OP_UNKNOWN;
    endcase
  end

endmodule

// File: rtl/scsi_sel_seq.sv
module scsi_sel_seq
  import scsi_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_i,
  input  logic     start_i,
  input  logic     stop_i,
  input  logic     dma_en_i,
  input  logic     done_i,
  input  logic     found_i,
  output logic     go_o,
  output sel_res_t res_o
);

  sel_st_e st_q, st_d;
  logic    stop_q, stop_d;
  logic    go_q, go_d;

  always_comb begin
    st_d   = st_q;
    stop_d = stop_q;
    go_d   = 1'b0;
    res_o  = '0;
    if (clr_i) begin
      st_d = S_IDLE;
    end else begin
      if (st_q == S_WAIT_BUS && done_i) begin
        res_o = '{valid: 1'b1, found: found_i, stop: stop_q};
        st_d  = S_IDLE;
      end
      if (st_q == S_WAIT_DMA && dma_en_i) begin
        go_d = 1'b1;
        st_d = S_WAIT_BUS;
      end
      if (start_i) begin
        stop_d = stop_i;
        if (dma_en_i) begin
          go_d = 1'b1;
          st_d = S_WAIT_BUS;
        end else begin
          go_d = 1'b0;
          st_d = S_WAIT_DMA;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      stop_q <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      stop_q <= stop_d;
      go_q   <= go_d;
    end
  end

  assign go_o = go_q;

  // R10: a selection is launched only with the DMA engine ready
  a_r10_go_needs_dma: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> $past(dma_en_i));

  // R10: a launched selection is then awaiting its answer
  a_r10_go_waits_bus: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> (st_q == S_WAIT_BUS));

endmodule

// File: rtl/scsi_ctl_regs.sv
module scsi_ctl_regs
  import scsi_ctl_pkg::*;
#(
  parameter int ADDR_SHIFT = 2,
  localparam int ADDR_W    = ADDR_SHIFT + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst,
  input  logic              dma_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq,
  output logic              sel_go,
  input  logic              sel_done,
  input  logic              sel_found
);

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_SHIFT +: IDX_W];

  generate
    if (ADDR_SHIFT > 0) begin : g_lo_bits
      logic unused_lo;
      assign unused_lo = ^addr[ADDR_SHIFT-1:0];
    end
  endgenerate

  // read-side image and the write-side copies that are used again
  regimg_t    rreg_q, rreg_d;
  logic [7:0] wlo_q, wlo_d, wmid_q, wmid_d, wcfg1_q, wcfg1_d;

  op_e      op;
  logic     cmd_dma;
  logic     sel_start, sel_clr;
  sel_res_t sel_res;
  logic     wr_cmd, rd_intr;

  assign wr_cmd  = wr_en && (idx == IX_CMD);
  assign rd_intr = rd_en && (idx == IX_INTR);

  scsi_cmd_decode u_dec (
    .cmd_i (wdata),
    .op_o  (op),
    .dma_o (cmd_dma)
  );

  scsi_sel_seq u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (sel_clr),
    .start_i  (sel_start),
    .stop_i   (op == OP_SELSTOP),
    .dma_en_i (dma_en),
    .done_i   (sel_done),
    .found_i  (sel_found),
    .go_o     (sel_go),
    .res_o    (sel_res)
  );

  always_comb begin
    rreg_d    = rreg_q;
    wlo_d     = wlo_q;
    wmid_d    = wmid_q;
    wcfg1_d   = wcfg1_q;
    sel_start = 1'b0;
    sel_clr   = 1'b0;
    if (ext_rst) begin
      rreg_d  = reset_image();
      wlo_d   = '0;
      wmid_d  = '0;
      wcfg1_d = '0;
      sel_clr = 1'b1;
    end else begin
      // read side effect of the interrupt register
      if (rd_intr) begin
        rreg_d[IX_INTR]          = '0;
        rreg_d[IX_SEQ]           = 8'd4;
        rreg_d[IX_STAT][ST_TCZ]  = 1'b0;
        rreg_d[IX_STAT][ST_PEND] = 1'b0;
      end
      // answer from the bus side to a selection
      if (sel_res.valid) begin
        if (!sel_res.found) begin
          rreg_d[IX_STAT] = 8'h80;
          rreg_d[IX_INTR] = IC_DISC;
          rreg_d[IX_SEQ]  = 8'd0;
        end else begin
          rreg_d[IX_INTR] = IC_SVC | IC_DONE;
          rreg_d[IX_SEQ]  = 8'd4;
          if (sel_res.stop) begin
            rreg_d[IX_STAT] = 8'h92;
          end else begin
            rreg_d[IX_STAT][ST_PEND] = 1'b1;
          end
        end
      end
      // host write
      if (wr_en) begin
        unique case (idx)
          IX_CNT_LO: begin
            wlo_d                   = wdata;
            rreg_d[IX_STAT][ST_TCZ] = 1'b0;
          end
          IX_CNT_MID: begin
            wmid_d                  = wdata;
            rreg_d[IX_STAT][ST_TCZ] = 1'b0;
          end
          IX_CMD: begin
            rreg_d[IX_CMD] = wdata;
            if (cmd_dma) begin
              rreg_d[IX_CNT_LO]  = wlo_q;
              rreg_d[IX_CNT_MID] = wmid_q;
            end
            unique case (op)
              OP_FLUSH: begin
                rreg_d[IX_INTR]  = IC_DONE;
                rreg_d[IX_SEQ]   = '0;
                rreg_d[IX_FLAGS] = '0;
              end
              OP_RESET: begin
                rreg_d  = reset_image();
                wlo_d   = '0;
                wmid_d  = '0;
                wcfg1_d = '0;
                sel_clr = 1'b1;
              end
              OP_BUSRST: begin
                rreg_d[IX_INTR] = IC_BUSRST;
                if (!wcfg1_q[CFG1_QUIET_BIT]) begin
                  rreg_d[IX_STAT][ST_PEND] = 1'b1;
                end
              end
              OP_XFER: begin
                if (cmd_dma) begin
                  rreg_d[IX_STAT][ST_TCZ] = 1'b0;
                end
              end
              OP_ICMPL: begin
                rreg_d[IX_INTR] = IC_DONE;
                if (cmd_dma) begin
                  rreg_d[IX_STAT] = 8'h97;
                  rreg_d[IX_SEQ]  = 8'd4;
                end else begin
                  rreg_d[IX_STAT]  = rreg_d[IX_STAT] | 8'h87;
                  rreg_d[IX_FLAGS] = 8'd2;
                end
              end
              OP_MSGACC: begin
                rreg_d[IX_INTR]          = IC_DISC;
                rreg_d[IX_SEQ]           = '0;
                rreg_d[IX_FLAGS]         = '0;
                rreg_d[IX_STAT][ST_PEND] = 1'b1;
              end
              OP_PAD: begin
                rreg_d[IX_STAT] = {rreg_d[IX_STAT][ST_PEND], 7'h10};
                rreg_d[IX_INTR] = IC_DONE;
                rreg_d[IX_SEQ]  = '0;
              end
              OP_SEL, OP_SELATN, OP_SELSTOP: begin
                sel_start = 1'b1;
              end
              OP_RESEL: begin
                rreg_d[IX_INTR] = '0;
              end
              default: begin
              end
            endcase
          end
          IX_CFG1: begin
            rreg_d[IX_CFG1] = wdata;
            wcfg1_d         = wdata;
          end
          4'hB, 4'hC, 4'hD, 4'hE, 4'hF: begin
            rreg_d[idx] = wdata;
          end
          default: begin
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rreg_q  <= reset_image();
      wlo_q   <= '0;
      wmid_q  <= '0;
      wcfg1_q <= '0;
    end else begin
      rreg_q  <= rreg_d;
      wlo_q   <= wlo_d;
      wmid_q  <= wmid_d;
      wcfg1_q <= wcfg1_d;
    end
  end

  assign rdata = rreg_q[idx];
  assign irq   = rreg_q[IX_STAT][ST_PEND];

  // R3: reading the interrupt register clears it and drops the line
  a_r3_intr_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_intr && !wr_en && !ext_rst && !sel_res.valid)
    |=> (!irq && rreg_q[IX_INTR] == 8'h00 && rreg_q[IX_SEQ] == 8'd4));

  // R4: a quiet bus reset leaves a low line low
  a_r4_busrst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata[6:0] == 7'h03 && wcfg1_q[CFG1_QUIET_BIT] && !irq
     && !ext_rst && !sel_res.valid) |=> !irq);

  // R5: pad never moves the interrupt line
  a_r5_pad_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata[6:0] == 7'h18 && !rd_intr && !ext_rst && !sel_res.valid)
    |=> (irq == $past(irq)));

  // R7: external reset restores the power-up image
  a_r7_ext_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |=> (!irq && rreg_q[IX_CFG1] == CFG1_INIT
                 && rreg_q[IX_CNT_HI] == CHIP_ID && rreg_q[IX_STAT] == 8'h00));

  // R11: an answered selection always raises the interrupt
  a_r11_select_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_res.valid && !ext_rst && !wr_en) |=> irq);

endmodule

// File: tb/scsi_ctl_regs_tb.sv
module scsi_ctl_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SH         = 2;

  logic       clk = 1'b0;
  logic       rst_n, ext_rst, dma_en, wr_en, rd_en, sel_done, sel_found;
  logic [5:0] addr;
  logic [7:0] wdata, rdata;
  logic       irq, sel_go;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_ctl_regs #(.ADDR_SHIFT(SH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .dma_en(dma_en),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .sel_go(sel_go),
    .sel_done(sel_done), .sel_found(sel_found)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] ix, input logic [7:0] v, input logic [1:0] lo = 2'b00);
    @(negedge clk);
    addr = {ix, lo}; wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] ix, output logic [7:0] v, input logic [1:0] lo = 2'b00);
    @(negedge clk);
    addr = {ix, lo}; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_done(input logic found);
    @(negedge clk);
    sel_done = 1'b1; sel_found = found;
    @(negedge clk);
    sel_done = 1'b0; sel_found = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(4'h8, v); chk("R1 cfg1", v, 8'h07);
    rd(4'hE, v); chk("R1 chip id", v, 8'h04);
    rd(4'h4, v); chk("R1 status", v, 8'h00);
    rd(4'h5, v); chk("R1 intr", v, 8'h00);
    rd(4'hB, v); chk("R1 cfg2", v, 8'h00);
  endtask

  task automatic t_addr();
    logic [7:0] v;
    wr(4'hB, 8'hA5, 2'b11);
    rd(4'hB, v, 2'b01); chk("R2 low bits ignored", v, 8'hA5);
    rd(4'hC, v, 2'b10); chk("R2 neighbour untouched", v, 8'h00);
  endtask

  task automatic t_config();
    logic [7:0] v;
    wr(4'hD, 8'h3C); rd(4'hD, v); chk("R8 cfg 0xD readback", v, 8'h3C);
    wr(4'h4, 8'hFF); rd(4'h4, v); chk("R8 bus id write hidden", v, 8'h00);
    wr(4'h9, 8'h55); rd(4'h9, v); chk("R8 clock factor hidden", v, 8'h00);
    wr(4'h0, 8'h34); wr(4'h1, 8'h12);
    rd(4'h0, v); chk("R8 count lo not yet loaded", v, 8'h00);
    wr(4'h3, 8'h80);
    rd(4'h0, v); chk("R8 count lo loaded", v, 8'h34);
    rd(4'h1, v); chk("R8 count mid loaded", v, 8'h12);
    rd(4'h3, v); chk("R8 command readback", v, 8'h80);
  endtask

  task automatic t_busrst();
    logic [7:0] v;
    wr(4'h8, 8'h40);
    wr(4'h3, 8'h03);
    chk("R4 quiet bus reset irq", {7'd0, irq}, 8'h00);
    rd(4'h5, v); chk("R4 quiet cause", v, 8'h80);
    wr(4'h8, 8'h00);
    wr(4'h3, 8'h03);
    chk("R4 loud bus reset irq", {7'd0, irq}, 8'h01);
    rd(4'h5, v); chk("R3 read returns old cause", v, 8'h80);
    chk("R3 irq dropped", {7'd0, irq}, 8'h00);
    rd(4'h5, v); chk("R3 cause cleared", v, 8'h00);
    rd(4'h6, v); chk("R3 sequence step 4", v, 8'h04);
  endtask

  task automatic t_pad();
    logic [7:0] v;
    wr(4'h3, 8'h18);
    chk("R5 pad keeps irq low", {7'd0, irq}, 8'h00);
    rd(4'h4, v); chk("R5 pad status", v, 8'h10);
    rd(4'h6, v); chk("R5 pad sequence", v, 8'h00);
    rd(4'h5, v); chk("R5 pad cause", v, 8'h08);
    rd(4'h4, v); chk("R3 read clears count-zero", v, 8'h00);
  endtask

  task automatic t_msgacc();
    logic [7:0] v;
    wr(4'h3, 8'h12);
    chk("R5 msg accept irq", {7'd0, irq}, 8'h01);
    rd(4'h6, v); chk("R5 msg accept sequence", v, 8'h00);
    rd(4'h7, v); chk("R5 msg accept flags", v, 8'h00);
    wr(4'h3, 8'h03);
    chk("R12 second raise keeps irq", {7'd0, irq}, 8'h01);
    rd(4'h5, v); chk("R12 cause after second event", v, 8'h80);
    chk("R12 single read drops irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_flush();
    logic [7:0] v;
    wr(4'h3, 8'h01);
    chk("R6 flush irq unchanged", {7'd0, irq}, 8'h00);
    rd(4'h6, v); chk("R6 flush sequence", v, 8'h00);
    wr(4'h3, 8'h44);
    rd(4'h5, v); chk("R6 reselect clears cause", v, 8'h00);
    wr(4'h3, 8'h01);
    wr(4'h3, 8'h7F);
    rd(4'h3, v); chk("R6 unknown stored", v, 8'h7F);
    rd(4'h6, v); chk("R6 unknown keeps sequence", v, 8'h00);
    rd(4'h4, v); chk("R6 unknown keeps status", v, 8'h00);
    wr(4'h3, 8'h1A);
    rd(4'h5, v); chk("R6 set-ATN keeps cause", v, 8'h08);
  endtask

  task automatic t_iccs();
    logic [7:0] v;
    wr(4'h3, 8'h11);
    chk("R9 iccs irq", {7'd0, irq}, 8'h01);
    rd(4'h4, v); chk("R9 iccs status", v, 8'h87);
    rd(4'h7, v); chk("R9 iccs flags", v, 8'h02);
    rd(4'h5, v); chk("R9 iccs cause", v, 8'h08);
    wr(4'h3, 8'h91);
    rd(4'h4, v); chk("R9 dma iccs status", v, 8'h97);
    rd(4'h6, v); chk("R9 dma iccs sequence", v, 8'h04);
    rd(4'h5, v); chk("R9 dma iccs cause", v, 8'h08);
  endtask

  task automatic t_xfer();
    logic [7:0] v;
    wr(4'h3, 8'h18);
    wr(4'h3, 8'h10);
    rd(4'h4, v); chk("R12 transfer w/o dma keeps tcz", v, 8'h10);
    wr(4'h3, 8'h90);
    rd(4'h4, v); chk("R12 dma transfer clears tcz", v, 8'h00);
    wr(4'h3, 8'h18);
    wr(4'h1, 8'h00);
    rd(4'h4, v); chk("R8 count write clears tcz", v, 8'h00);
  endtask

  task automatic t_select();
    logic [7:0] v;
    rd(4'h5, v);
    dma_en = 1'b0;
    wr(4'h3, 8'h43);
    chk("R10 no go without dma", {7'd0, sel_go}, 8'h00);
    pulse_done(1'b1);
    rd(4'h5, v); chk("R10 done ignored while waiting for dma", v, 8'h00);
    @(negedge clk); dma_en = 1'b1;
    @(negedge clk);
    chk("R10 go after dma", {7'd0, sel_go}, 8'h01);
    @(negedge clk);
    chk("R10 go is one cycle", {7'd0, sel_go}, 8'h00);
    pulse_done(1'b1);
    chk("R11 stop found irq", {7'd0, irq}, 8'h01);
    rd(4'h4, v); chk("R11 stop found status", v, 8'h92);
    rd(4'h6, v); chk("R11 stop found sequence", v, 8'h04);
    rd(4'h5, v); chk("R11 stop found cause", v, 8'h18);
    wr(4'h3, 8'h41);
    chk("R10 go with dma ready", {7'd0, sel_go}, 8'h01);
    pulse_done(1'b0);
    rd(4'h4, v); chk("R11 missing status", v, 8'h80);
    rd(4'h6, v); chk("R11 missing sequence", v, 8'h00);
    rd(4'h5, v); chk("R11 missing cause", v, 8'h20);
    wr(4'h3, 8'h18);
    wr(4'h3, 8'h42);
    pulse_done(1'b1);
    rd(4'h4, v); chk("R11 found keeps status bits", v, 8'h90);
    rd(4'h5, v); chk("R11 found cause", v, 8'h18);
    pulse_done(1'b1);
    chk("R10 idle done ignored irq", {7'd0, irq}, 8'h00);
    rd(4'h5, v); chk("R10 idle done ignored cause", v, 8'h00);
  endtask

  task automatic t_resets();
    logic [7:0] v;
    wr(4'hF, 8'h77); wr(4'h8, 8'h40); wr(4'h3, 8'h12);
    wr(4'h3, 8'h02);
    chk("R7 reset command drops irq", {7'd0, irq}, 8'h00);
    rd(4'hF, v); chk("R7 cfg cleared", v, 8'h00);
    rd(4'h8, v); chk("R7 cfg1 init", v, 8'h07);
    rd(4'h3, v); chk("R7 command reg cleared", v, 8'h00);
    wr(4'h3, 8'h03);
    chk("R1 write copy of cfg1 zero", {7'd0, irq}, 8'h01);
    wr(4'hE, 8'h99);
    @(negedge clk); ext_rst = 1'b1;
    @(negedge clk); ext_rst = 1'b0;
    chk("R7 ext reset drops irq", {7'd0, irq}, 8'h00);
    rd(4'hE, v); chk("R7 ext reset chip id", v, 8'h04);
    rd(4'h5, v); chk("R7 ext reset cause", v, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; ext_rst = 1'b0; dma_en = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    sel_done = 1'b0; sel_found = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr();
    t_config();
    t_busrst();
    t_pad();
    t_msgacc();
    t_flush();
    t_iccs();
    t_xfer();
    t_select();
    t_resets();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule